// File: doc/BRIEF.md
# Paged Flash Window Bridge

This block lets a host on a two-wire serial bus reach an external SPI flash one 256-byte page at a time. The serial target front end is already decoded into byte events: a start marker that carries the 7-bit device address, write strobes with a data byte, read strobes that ask for one byte, and a stop marker. Two device addresses are served. The register port at 0x4A holds the page-select registers and a write-unlock register. The window port at 0x4F streams bytes to or from the selected page.

A window read opens an SPI READ frame on the page address and returns one flash byte for each read strobe. At the end of the page it wraps back to the page start. A window write begins with an offset byte, collects up to 256 data bytes into a page buffer, and at the stop marker sends a write-enable frame followed by a page-program frame. A busy output covers the whole programming sequence. The SPI side is a mode-0 master: SCLK idles low, MOSI changes while SCLK is low, and MISO is sampled at the end of the high phase.

Top module: `flash_page_bridge`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sclk is 0, busy is 0, bus_rvalid is 0, both page registers read 0 and hardware write is disabled.
- R2: At device address 0x4A the first write byte of a transfer selects a register index. Later write bytes store into that register: index 0x8E holds flash address bits [15:8] and index 0x8F holds bits [23:16]. A read strobe returns the selected register with bus_rvalid high on the cycle after the strobe.
- R3: Writing 0x55 to register index 0xDA enables hardware page write. Any other value disables it. Reading index 0xDA returns 0x01 when enabled and 0x00 when disabled.
- R4: A window read sends 0x03 and then the address {bits 23:16, bits 15:8, offset} in one chip-select-low frame. The offset is the first byte written in the most recent window transfer, and it is 0 after reset. Each read strobe returns the next flash byte as a single-cycle bus_rvalid pulse.
- R5: After the byte at offset 0xFF, the next read strobe closes the frame and reopens it at offset 0x00 of the same page.
- R6: In a window write the first byte is the offset and the following bytes are data. At stop, if at least one data byte was given, the block sends 0x06 in its own frame and then 0x02, the 3-byte address and the data bytes in order, all in one chip-select-low frame.
- R7: While hardware write is disabled, window data bytes are ignored and a stop starts no SPI frame.
- R8: A window write with more than 256 data bytes is dropped whole, and no SPI frame follows its stop.
- R9: busy rises on the cycle after the stop that starts programming and falls when the program frame closes. A window transfer started while busy is high is ignored: its read strobes give no bus_rvalid and no SPI frame.
- R10: Transfers to any device address other than 0x4A and 0x4F change no state.
- R11: A write of exactly 256 data bytes programs all 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated-start marker, one cycle |
| bus_dev | input | 7 | 7-bit device address, valid with bus_start |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe asking for one byte |
| bus_stop | input | 1 | Stop marker, one cycle |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle pulse when bus_rdata is valid |
| busy | output | 1 | Program sequence in progress |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
A register read answers exactly one cycle after its strobe. Busy must be high one cycle after the stop marker, so the bench checks both at the next falling clock edge. Each SPI byte takes 17 cycles from the cycle it is issued. The first window byte is therefore due about 86 cycles after its strobe, and each later byte about 18 cycles after its strobe. The bench does not count these cycles: it polls bus_rvalid and busy at falling edges under a bounded wait. A small flash model in the bench decodes every SPI frame, and the bench compares what the model captured against values it computes from the requirements.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    localparam int BYTE_W     = 8;
    localparam int PAGE_BYTES = 256;
    localparam int PTR_W      = $clog2(PAGE_BYTES);
    localparam int CNT_W      = PTR_W + 1;
    localparam int BIT_CNT_W  = $clog2(2 * BYTE_W);

    localparam logic [6:0] REG_DEV = 7'h4A;
    localparam logic [6:0] WIN_DEV = 7'h4F;

    localparam logic [7:0] IDX_MID    = 8'h8E;
    localparam logic [7:0] IDX_HI     = 8'h8F;
    localparam logic [7:0] IDX_UNLOCK = 8'hDA;
    localparam logic [7:0] UNLOCK_KEY = 8'h55;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_DUMMY = 8'h00;

    typedef enum logic [2:0] {
        S_IDLE, S_RGAP, S_RHDR, S_RBYTE, S_WEN, S_WGAP, S_PHDR, S_PDATA
    } seq_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] mid;
        logic [7:0] off;
    } flash_addr_t;

    function automatic logic [7:0] hdr_byte(input logic [7:0] op,
                                            input flash_addr_t a,
                                            input logic [1:0] idx);
        case (idx)
            2'd0:    return op;
            2'd1:    return a.hi;
            2'd2:    return a.mid;
            default: return a.off;
        endcase
    endfunction
endpackage

// File: rtl/fpb_regs.sv
module fpb_regs import fpb_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             sess_start,
    input  logic             sel,
    input  logic             wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic             rd,
    output logic [BYTE_W-1:0] page_hi,
    output logic [BYTE_W-1:0] page_mid,
    output logic             hw_en,
    output logic [BYTE_W-1:0] rdata,
    output logic             rvalid
);
    logic [BYTE_W-1:0] idx;
    logic              have_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            have_idx <= 1'b0;
            page_hi  <= '0;
            page_mid <= '0;
            hw_en    <= 1'b0;
            rdata    <= '0;
            rvalid   <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            if (sess_start) begin
                have_idx <= 1'b0;
            end else if (sel && wr) begin
                if (!have_idx) begin
                    idx      <= wdata;
                    have_idx <= 1'b1;
                end else begin
                    case (idx)
                        IDX_MID:    page_mid <= wdata;
                        IDX_HI:     page_hi  <= wdata;
                        IDX_UNLOCK: hw_en    <= (wdata == UNLOCK_KEY);
                        default:    ;
                    endcase
                end
            end
            if (sel && rd) begin
                rvalid <= 1'b1;
                case (idx)
                    IDX_MID:    rdata <= page_mid;
                    IDX_HI:     rdata <= page_hi;
                    IDX_UNLOCK: rdata <= {{(BYTE_W-1){1'b0}}, hw_en};
                    default:    rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpb_spi_byte.sv
module fpb_spi_byte import fpb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx
);
    logic [BIT_CNT_W-1:0] cnt;
    logic                 active;
    logic [BYTE_W-1:0]    sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
            sh     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                sh     <= tx;
                cnt    <= '0;
                active <= 1'b1;
            end else if (active) begin
                cnt <= cnt + 1'b1;
                if (cnt[0]) sh <= {sh[BYTE_W-2:0], miso};
                if (cnt == BIT_CNT_W'(2 * BYTE_W - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign sclk = active & cnt[0];
    assign mosi = sh[BYTE_W-1];
    assign rx   = sh;
endmodule

// File: rtl/fpb_page_buf.sv
module fpb_page_buf #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_page_bridge.sv
module flash_page_bridge import fpb_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_start,
    input  logic [6:0] bus_dev,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    input  logic       bus_stop,
    output logic [7:0] bus_rdata,
    output logic       bus_rvalid,
    output logic       busy,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic              reg_sess, win_sess, first, ovf, stream_open;
    logic [CNT_W-1:0]  wcnt, pidx;
    logic [PTR_W-1:0]  rd_ptr, off;
    logic [1:0]        hdr_idx;
    logic              go, done;
    logic [7:0]        tx, rx, buf_q, rdata_w;
    logic              rvalid_w;
    seq_state_e        st;
    flash_addr_t       prog_a, rd_a;

    logic [7:0] page_hi, page_mid, reg_rdata;
    logic       hw_en, reg_rvalid;

    // Window strobes and the conditions that start a program sequence.
    logic win_wr, win_rd, buf_we, prog_ok;
    assign win_wr  = win_sess && bus_wr;
    assign win_rd  = win_sess && bus_rd;
    assign buf_we  = win_wr && !first && hw_en && (wcnt < CNT_W'(PAGE_BYTES));
    assign prog_ok = win_sess && hw_en && (wcnt != '0) && !ovf;
    assign rd_a    = '{hi: page_hi, mid: page_mid, off: rd_ptr};

    fpb_regs i_regs (
        .clk(clk), .rst(rst), .sess_start(bus_start), .sel(reg_sess),
        .wr(bus_wr), .wdata(bus_wdata), .rd(bus_rd),
        .page_hi(page_hi), .page_mid(page_mid), .hw_en(hw_en),
        .rdata(reg_rdata), .rvalid(reg_rvalid)
    );

    fpb_spi_byte i_shift (
        .clk(clk), .rst(rst), .go(go), .tx(tx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(done), .rx(rx)
    );

    fpb_page_buf #(.DEPTH(PAGE_BYTES), .WIDTH(BYTE_W)) i_buf (
        .clk(clk), .wr_en(buf_we), .wr_addr(wcnt[PTR_W-1:0]), .wr_data(bus_wdata),
        .rd_addr(pidx[PTR_W-1:0]), .rd_data(buf_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_sess <= 1'b0; win_sess <= 1'b0; first <= 1'b0; ovf <= 1'b0;
            stream_open <= 1'b0; wcnt <= '0; pidx <= '0; rd_ptr <= '0; off <= '0;
            hdr_idx <= '0; go <= 1'b0; tx <= '0; rdata_w <= '0; rvalid_w <= 1'b0;
            busy <= 1'b0; spi_cs_n <= 1'b1; prog_a <= '0; st <= S_IDLE;
        end else begin
            go       <= 1'b0;
            rvalid_w <= 1'b0;
            if (bus_start) begin
                reg_sess <= (bus_dev == REG_DEV);
                win_sess <= (bus_dev == WIN_DEV) && !busy;
                if ((bus_dev == WIN_DEV) && !busy) begin
                    first <= 1'b1;
                    wcnt  <= '0;
                    ovf   <= 1'b0;
                end
            end
            if (bus_stop) begin
                reg_sess <= 1'b0;
                win_sess <= 1'b0;
            end
            if (win_wr) begin
                if (first) begin
                    off    <= bus_wdata;
                    rd_ptr <= bus_wdata;
                    first  <= 1'b0;
                end else if (hw_en) begin
                    if (wcnt == CNT_W'(PAGE_BYTES)) ovf <= 1'b1;
                    else                            wcnt <= wcnt + 1'b1;
                end
            end
            case (st)
                S_IDLE: begin
                    if (bus_stop && prog_ok) begin
                        busy        <= 1'b1;
                        prog_a      <= '{hi: page_hi, mid: page_mid, off: off};
                        spi_cs_n    <= 1'b0;
                        go          <= 1'b1;
                        tx          <= OP_WREN;
                        stream_open <= 1'b0;
                        st          <= S_WEN;
                    end else if ((bus_start || bus_stop) && stream_open) begin
                        spi_cs_n    <= 1'b1;
                        stream_open <= 1'b0;
                    end else if (win_rd) begin
                        if (stream_open && rd_ptr != '0) begin
                            go <= 1'b1;
                            tx <= OP_DUMMY;
                            st <= S_RBYTE;
                        end else if (stream_open) begin
                            spi_cs_n <= 1'b1;      // page wrap: close and reopen
                            st       <= S_RGAP;
                        end else begin
                            spi_cs_n    <= 1'b0;
                            go          <= 1'b1;
                            tx          <= OP_READ;
                            hdr_idx     <= '0;
                            stream_open <= 1'b1;
                            st          <= S_RHDR;
                        end
                    end
                end
                S_RGAP: begin
                    spi_cs_n    <= 1'b0;
                    go          <= 1'b1;
                    tx          <= OP_READ;
                    hdr_idx     <= '0;
                    stream_open <= 1'b1;
                    st          <= S_RHDR;
                end
                S_RHDR: if (done) begin
                    go <= 1'b1;
                    if (hdr_idx == 2'd3) begin
                        tx <= OP_DUMMY;
                        st <= S_RBYTE;
                    end else begin
                        hdr_idx <= hdr_idx + 2'd1;
                        tx      <= hdr_byte(OP_READ, rd_a, hdr_idx + 2'd1);
                    end
                end
                S_RBYTE: if (done) begin
                    rdata_w  <= rx;
                    rvalid_w <= 1'b1;
                    rd_ptr   <= rd_ptr + 1'b1;
                    st       <= S_IDLE;
                end
                S_WEN: if (done) begin
                    spi_cs_n <= 1'b1;
                    st       <= S_WGAP;
                end
                S_WGAP: begin
                    spi_cs_n <= 1'b0;
                    go       <= 1'b1;
                    tx       <= OP_PROG;
                    hdr_idx  <= '0;
                    pidx     <= '0;
                    st       <= S_PHDR;
                end
                S_PHDR: if (done) begin
                    go <= 1'b1;
                    if (hdr_idx == 2'd3) begin
                        tx   <= buf_q;
                        pidx <= pidx + 1'b1;
                        st   <= S_PDATA;
                    end else begin
                        hdr_idx <= hdr_idx + 2'd1;
                        tx      <= hdr_byte(OP_PROG, prog_a, hdr_idx + 2'd1);
                    end
                end
                S_PDATA: if (done) begin
                    if (pidx == wcnt) begin
                        spi_cs_n <= 1'b1;
                        busy     <= 1'b0;
                        st       <= S_IDLE;
                    end else begin
                        go   <= 1'b1;
                        tx   <= buf_q;
                        pidx <= pidx + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign bus_rvalid = rvalid_w | reg_rvalid;
    assign bus_rdata  = reg_rvalid ? reg_rdata : rdata_w;
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cs_n,
    input logic sclk,
    input logic mosi
);
    // R6: the SPI clock only runs inside a chip-select-low frame
    p_sclk_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R6: MOSI holds its value through the high phase of SCLK
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    // R9: busy starts together with the write-enable frame
    p_busy_opens_frame_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !cs_n);

    // R9: busy ends together with the close of the program frame
    p_busy_closes_frame_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> cs_n);

    // R6: within a program sequence chip select is high for one cycle at most
    p_short_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && cs_n) |=> !cs_n);
endmodule

bind flash_page_bridge fpb_checker i_fpb_checker (
    .clk(clk), .rst(rst), .busy(busy),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi)
);

// File: tb/test_flash_page_bridge.sv
module test_flash_page_bridge;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
    logic [6:0] bus_dev = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid, busy, spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_page_bridge i_flash_page_bridge (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_dev(bus_dev),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_stop(bus_stop),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    function automatic logic [7:0] mem_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    logic [7:0]  f_sh = '0, f_cmd = '0, f_out = '0;
    logic [23:0] f_addr = '0, prog_addr = '0;
    int          f_bits = 0, f_idx = 0, frames = 0, n_prog = 0, prog_len = 0;
    logic        f_wel = 1'b0, prog_wel = 1'b0;
    logic [7:0]  prog_data [256];

    always @(negedge spi_cs_n) begin
        f_bits = 0; f_idx = 0; f_out = '0; f_cmd = '0; frames++;
    end

    always @(posedge spi_sclk) begin
        f_sh = {f_sh[6:0], spi_mosi};
        f_bits++;
        if (f_bits == 8) begin
            f_bits = 0;
            case (f_idx)
                0: f_cmd = f_sh;
                1: f_addr[23:16] = f_sh;
                2: f_addr[15:8] = f_sh;
                3: f_addr[7:0] = f_sh;
                default: if (f_cmd == 8'h02 && f_idx - 4 < 256) prog_data[f_idx - 4] = f_sh;
            endcase
            if (f_cmd == 8'h03 && f_idx >= 3) begin
                f_out  = mem_at(f_addr);
                f_addr = f_addr + 24'd1;
            end
            f_idx++;
        end
    end

    always @(negedge spi_sclk) spi_miso = f_out[3'(7 - f_bits)];

    always @(posedge spi_cs_n) begin
        if (frames > 0) begin
            if (f_cmd == 8'h06 && f_idx == 1) f_wel = 1'b1;
            if (f_cmd == 8'h02) begin
                n_prog++;
                prog_addr = f_addr;
                prog_len  = f_idx - 4;
                prog_wel  = f_wel;
                f_wel     = 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic b_start(input logic [6:0] dev);
        @(negedge clk); bus_start = 1'b1; bus_dev = dev;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic b_write(input logic [7:0] b);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic b_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic b_read(output logic [7:0] d, output bit got);
        got = 1'b0; d = '0;
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (bus_rvalid) begin got = 1'b1; d = bus_rdata; break; end
            @(negedge clk);
        end
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
        b_start(7'h4A); b_write(idx); b_write(v); b_stop();
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d, output bit got);
        b_start(7'h4A); b_write(idx); b_start(7'h4A); b_read(d, got); b_stop();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] d; bit g;
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 spi idle", {spi_cs_n, spi_sclk}, 2'b10);
        check(busy === 1'b0 && bus_rvalid === 1'b0, "R1 busy/rvalid", {busy, bus_rvalid}, 0);
        reg_read(8'h8E, d, g);
        check(g && d == 8'h00, "R1 page mid reset", d, 0);
        reg_read(8'hDA, d, g);
        check(g && d == 8'h00, "R1 write disabled at reset", d, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d; bit g;
        reg_write(8'h8E, 8'h34);
        reg_write(8'h8F, 8'h12);
        b_start(7'h4A); b_write(8'h8E); b_start(7'h4A);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        check(bus_rvalid === 1'b1 && bus_rdata == 8'h34, "R2 mid one cycle after strobe", bus_rdata, 8'h34);
        b_stop();
        reg_read(8'h8F, d, g);
        check(g && d == 8'h12, "R2 hi readback", d, 8'h12);
    endtask

    task automatic t_unlock();
        logic [7:0] d; bit g;
        reg_write(8'hDA, 8'h55);
        reg_read(8'hDA, d, g);
        check(g && d == 8'h01, "R3 unlock key", d, 1);
        reg_write(8'hDA, 8'h33);
        reg_read(8'hDA, d, g);
        check(g && d == 8'h00, "R3 other value locks", d, 0);
    endtask

    task automatic t_read();
        logic [7:0] d; bit g; int fr;
        fr = frames;
        b_start(7'h4F); b_write(8'h10); b_start(7'h4F);
        for (int i = 0; i < 4; i++) begin
            b_read(d, g);
            check(g && d == mem_at({16'h1234, 8'(8'h10 + i)}), "R4 window read byte", d,
                  mem_at({16'h1234, 8'(8'h10 + i)}));
        end
        check(frames == fr + 1 && f_cmd == 8'h03, "R4 one read frame", frames - fr, 1);
        b_stop();
        @(negedge clk);
        check(spi_cs_n === 1'b1, "R4 frame closed at stop", spi_cs_n, 1);
    endtask

    task automatic t_wrap();
        logic [7:0] d; bit g; int fr;
        logic [7:0] offs [3] = '{8'hFE, 8'hFF, 8'h00};
        fr = frames;
        b_start(7'h4F); b_write(8'hFE); b_start(7'h4F);
        for (int i = 0; i < 3; i++) begin
            b_read(d, g);
            check(g && d == mem_at({16'h1234, offs[i]}), "R5 wrap read", d, mem_at({16'h1234, offs[i]}));
        end
        check(frames == fr + 2, "R5 frame reopened", frames - fr, 2);
        b_stop();
    endtask

    task automatic t_disabled();
        int fr, np;
        reg_write(8'hDA, 8'h00);
        fr = frames; np = n_prog;
        b_start(7'h4F); b_write(8'h00);
        for (int i = 0; i < 4; i++) b_write(8'(i));
        b_stop();
        repeat (100) @(negedge clk);
        check(frames == fr && n_prog == np && !busy, "R7 locked write ignored", frames - fr, 0);
    endtask

    task automatic t_write();
        int np;
        logic [7:0] pat [5] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01};
        reg_write(8'hDA, 8'h55);
        np = n_prog;
        b_start(7'h4F); b_write(8'h00);
        for (int i = 0; i < 5; i++) b_write(pat[i]);
        b_stop();
        check(busy === 1'b1, "R9 busy after stop", busy, 1);
        wait_idle();
        check(n_prog == np + 1 && prog_wel, "R6 enable then program", n_prog - np, 1);
        check(prog_len == 5, "R6 program length", prog_len, 5);
        check(prog_addr == 24'h123400, "R6 program address", prog_addr, 24'h123400);
        for (int i = 0; i < 5; i++)
            check(prog_data[i] == pat[i], "R6 program data", prog_data[i], pat[i]);
    endtask

    task automatic t_busy_ignore();
        bit seen; int fr;
        b_start(7'h4F); b_write(8'h00);
        for (int i = 0; i < 3; i++) b_write(8'h40 + 8'(i));
        fr = frames;
        b_stop();
        b_start(7'h4F);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 150; i++) begin
            if (bus_rvalid) seen = 1'b1;
            @(negedge clk);
        end
        b_stop();
        wait_idle();
        repeat (20) @(negedge clk);
        check(!seen, "R9 read while busy ignored", seen, 0);
        check(frames == fr + 2, "R9 only program frames", frames - fr, 2);
    endtask

    task automatic t_full();
        int np;
        np = n_prog;
        b_start(7'h4F); b_write(8'h00);
        for (int i = 0; i < 256; i++) b_write(8'(i * 3));
        b_stop();
        wait_idle();
        check(n_prog == np + 1 && prog_len == 256, "R11 full page length", prog_len, 256);
        check(prog_data[0] == 8'h00 && prog_data[255] == 8'(255 * 3), "R11 full page ends",
              prog_data[255], 8'(255 * 3));
    endtask

    task automatic t_overflow();
        int np, fr;
        np = n_prog; fr = frames;
        b_start(7'h4F); b_write(8'h00);
        for (int i = 0; i < 257; i++) b_write(8'h77);
        b_stop();
        repeat (100) @(negedge clk);
        check(n_prog == np && frames == fr && !busy, "R8 overflow dropped", n_prog - np, 0);
    endtask

    task automatic t_other_dev();
        logic [7:0] d; bit g; bit seen; int fr;
        fr = frames;
        b_start(7'h50); b_write(8'h8E); b_write(8'h99);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (bus_rvalid) seen = 1'b1;
            @(negedge clk);
        end
        b_stop();
        check(!seen && frames == fr, "R10 foreign read silent", seen, 0);
        reg_read(8'h8E, d, g);
        check(g && d == 8'h34, "R10 foreign write ignored", d, 8'h34);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_unlock();
        t_read();
        t_wrap();
        t_disabled();
        t_write();
        t_busy_ignore();
        t_full();
        t_overflow();
        t_other_dev();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule